// File: doc/BRIEF.md
# Iterative Unsigned Multiply/Divide Unit

A small arithmetic coprocessor sitting on a byte-wide register port. Software writes a multiplicand and then a multiplier to get an 8×8 unsigned product, or writes a two-byte dividend and then a divisor to get a 16÷8 unsigned quotient and remainder. Writing the second operand is the start command. There is no separate start bit.

The multiply advances one shift-and-add step per clock and finishes in 8 cycles. The divide advances one restoring step per clock and finishes in 16 cycles. A single 16-bit result register holds the product after a multiply and the remainder after a divide. The quotient has its own 16-bit register.

All registers are reached one byte at a time. A `busy` output marks the cycles in which stepping is in progress. Reads taken while `busy` is high return the partially built values.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` is low and every readable byte (addresses 5 to 8) reads 0x00.
- R2: A write to address 1 loads the multiplier and starts a multiply of it by the byte last written to address 0. `busy` is high for exactly the 8 cycles after the write. The product is then readable at address 7 (low byte) and address 8 (high byte).
- R3: A write to address 4 loads the divisor and starts a divide of {byte at address 3, byte at address 2} by it. `busy` is high for exactly the 16 cycles after the write. The quotient is then readable at address 5 (low) and address 6 (high), and the remainder at addresses 7 (low) and 8 (high).
- R4: A divisor of zero yields a quotient of 0xFFFF and a remainder equal to the dividend.
- R5: After k completed steps, the result register reads as follows. For a multiply it reads A·(B mod 2^k). For a divide it reads (D>>(16−k)) mod d, and the quotient register reads the low 16 bits of (D<<k) | ⌊(D>>(16−k))/d⌋. For a divide by zero, the partial quotient term is 2^k−1 and the result register reads D>>(16−k).
- R6: Writes to addresses 0, 2 or 3 while an operation runs do not alter that operation. They only set operands for a later start.
- R7: A start write (address 1 or 4) arriving while an operation is running abandons it and begins the new operation from its first step. This includes a start write in the final step cycle.
- R8: A multiply leaves the quotient register unchanged. When idle, both result registers hold their values.
- R9: Addresses 0 to 4 and 9 to 15 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational from addr) |
| busy | output | 1 | Operation in progress |

## Verification
The interesting coincidences are stepping and register writes landing on the same clock edge. One case is a start write arriving on a cycle where a running operation would otherwise take its next or last step. The other is an operand write arriving mid-operation. The bench provokes both: it restarts a multiply with a divide partway through, and it starts a multiply on the exact edge of a divide's sixteenth step. It also rewrites factor A and both dividend bytes while a divide runs. A behavioural model tracks step count and captured operands and predicts every result byte and `busy` on every cycle, so the bench flags any lost step, any extra step, or any leak of a late operand.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          busy
);
  localparam int MUL_STEPS = 8;
  localparam int DIV_STEPS = 16;
  localparam int CW = $clog2(DIV_STEPS + 1);
  localparam logic [AW-1:0] A_FA = 0, A_FB = 1, A_DL = 2, A_DH = 3, A_DV = 4;
  localparam logic [AW-1:0] A_QL = 5, A_QH = 6, A_RL = 7, A_RH = 8;

  logic [7:0]    fa_r, dl_r, dh_r, dv_r, mplier_r;
  logic [15:0]   mcand_r, quot_r, res_r;
  logic [CW-1:0] cnt_r;
  logic          is_mul_r;

  logic start_mul, start_div;
  assign start_mul = wr_en && addr == A_FB;
  assign start_div = wr_en && addr == A_DV;
  assign busy = cnt_r != '0;

  logic [16:0] trial, diff;
  assign trial = {res_r, quot_r[15]};
  assign diff  = trial - {9'd0, dv_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_r <= '0; dl_r <= '0; dh_r <= '0; dv_r <= '0;
      mplier_r <= '0; mcand_r <= '0; quot_r <= '0; res_r <= '0;
      cnt_r <= '0; is_mul_r <= 1'b0;
    end else begin
      if (wr_en && addr == A_FA) fa_r <= wdata;
      if (wr_en && addr == A_DL) dl_r <= wdata;
      if (wr_en && addr == A_DH) dh_r <= wdata;
      if (start_mul) begin
        mcand_r  <= {8'd0, fa_r};
        mplier_r <= wdata;
        res_r    <= '0;
        cnt_r    <= CW'(MUL_STEPS);
        is_mul_r <= 1'b1;
      end else if (start_div) begin
        dv_r     <= wdata;
        quot_r   <= {dh_r, dl_r};
        res_r    <= '0;
        cnt_r    <= CW'(DIV_STEPS);
        is_mul_r <= 1'b0;
      end else if (busy) begin
        cnt_r <= cnt_r - 1'b1;
        if (is_mul_r) begin
          if (mplier_r[0]) res_r <= res_r + mcand_r;
          mcand_r  <= mcand_r << 1;
          mplier_r <= mplier_r >> 1;
        end else if (!diff[16]) begin
          res_r  <= diff[15:0];
          quot_r <= {quot_r[14:0], 1'b1};
        end else begin
          res_r  <= trial[15:0];
          quot_r <= {quot_r[14:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_QL:    rdata = quot_r[7:0];
      A_QH:    rdata = quot_r[15:8];
      A_RL:    rdata = res_r[7:0];
      A_RH:    rdata = res_r[15:8];
      default: rdata = 8'd0;
    endcase
  end
endmodule

module muldiv_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [7:0]  rdata,
  input logic        busy,
  input logic [15:0] quot_r,
  input logic [15:0] res_r
);
  logic       start, is_mul;
  logic [4:0] n;
  assign start = wr_en && (addr == 4'd1 || addr == 4'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n <= '0; is_mul <= 1'b0;
    end else if (start) begin
      n <= 5'd1; is_mul <= addr == 4'd1;
    end else if (n != 5'd0 && n != 5'd31) begin
      n <= n + 5'd1;
    end
  end

  // R2 R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  // R2 R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> n == (is_mul ? 5'd9 : 5'd17));
  // R8
  mul_keeps_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_mul && !start) |=> $stable(quot_r));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(res_r) && $stable(quot_r)));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < 4'd5 || addr > 4'd8) |-> rdata == 8'd0);
endmodule

bind muldiv_unit muldiv_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .busy(busy), .quot_r(quot_r), .res_r(res_r)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic busy;

  always #10 clk = ~clk;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  int checks = 0, fails = 0;
  string ph = "R1";

  int fa, dl, dh, op, k, ma, mb, dd, dv, qhold;

  function automatic int steps();
    return op == 1 ? 8 : 16;
  endfunction
  function automatic bit exp_busy();
    return op != 0 && k < steps();
  endfunction
  function automatic int exp_q();
    int t, q;
    if (op != 2) return qhold;
    t = dd >> (16 - k);
    q = (dv == 0) ? (1 << k) - 1 : t / dv;
    return ((dd << k) | q) & 65535;
  endfunction
  function automatic int exp_r();
    int t;
    if (op == 1) return ma * (mb % (1 << k));
    if (op == 2) begin
      t = dd >> (16 - k);
      return (dv == 0) ? t : t % dv;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    int cq;
    if (!rst_n) begin
      fa = 0; dl = 0; dh = 0; op = 0; k = 0; ma = 0; mb = 0; dd = 0; dv = 0; qhold = 0;
    end else begin
      cq = exp_q();
      if (wr_en && addr == 1) begin
        qhold = cq; op = 1; k = 0; ma = fa; mb = wdata;
      end else if (wr_en && addr == 4) begin
        op = 2; k = 0; dd = dh * 256 + dl; dv = wdata;
      end else if (exp_busy()) k++;
      if (wr_en && addr == 0) fa = wdata;
      if (wr_en && addr == 2) dl = wdata;
      if (wr_en && addr == 3) dh = wdata;
    end
  end

  task automatic check(int act, int exp, string what);
    string tag;
    tag = exp_busy() ? "R5" : ph;
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit we, int a, int d);
    wr_en = we; addr = 4'(a); wdata = 8'(d);
    @(posedge clk);
    #5;
    wr_en = 1'b0;
    for (int i = 5; i <= 8; i++) begin
      int e;
      addr = 4'(i);
      #1;
      case (i)
        5: e = exp_q() & 255;
        6: e = (exp_q() >> 8) & 255;
        7: e = exp_r() & 255;
        default: e = (exp_r() >> 8) & 255;
      endcase
      check(int'(rdata), e, $sformatf("byte@%0d", i));
    end
    check(int'(busy), int'(exp_busy()), "busy");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
  endtask

  task automatic zsweep();
    @(posedge clk);
    #2;
    for (int a = 0; a < 16; a++) begin
      if (a >= 5 && a <= 8) continue;
      addr = 4'(a);
      #1;
      check(int'(rdata), 0, $sformatf("unmapped@%0d", a));
    end
  endtask

  task automatic mul(int a, int b);
    cyc(1'b1, 0, a); cyc(1'b1, 1, b); idle(10);
  endtask
  task automatic div(int d, int v);
    cyc(1'b1, 2, d & 255); cyc(1'b1, 3, d >> 8); cyc(1'b1, 4, v); idle(18);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    ph = "R1"; idle(2);
    ph = "R9"; zsweep();
    ph = "R2"; mul(8'hD3, 8'hB7); mul(255, 255); mul(0, 8'h5A); mul(8'h81, 1);
    ph = "R3"; div(16'hBEEF, 8'h3A); div(16'h0007, 9); div(16'hFFFF, 1); div(16'hFFFF, 255);
    ph = "R4"; div(16'h1234, 0); div(16'hFFFF, 0);
    ph = "R8"; mul(8'h12, 8'h34); idle(4);
    ph = "R6";
    cyc(1'b1, 2, 8'h10); cyc(1'b1, 3, 8'h27); cyc(1'b1, 4, 8'h0D);
    idle(3); cyc(1'b1, 0, 8'h99); cyc(1'b1, 2, 8'hFF); cyc(1'b1, 3, 8'hEE); idle(14);
    cyc(1'b1, 1, 8'h03); idle(10);
    ph = "R7";
    cyc(1'b1, 0, 8'hC5); cyc(1'b1, 1, 8'hE9); idle(3);
    cyc(1'b1, 2, 8'h34); cyc(1'b1, 3, 8'h12); cyc(1'b1, 4, 8'h21); idle(15);
    cyc(1'b1, 1, 8'h77); idle(10);
    cyc(1'b1, 1, 8'h0F); idle(2); cyc(1'b1, 1, 8'hF0); idle(10);
    ph = "R9"; zsweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL %s watchdog act=timeout exp=done", ph);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule